// File: doc/BRIEF.md
# Block Motion-Compensation Reconstructor

This block rebuilds one 8x8 luma block of a decoded picture from its inverse-transformed residual samples. A command carries the block position (in block units), a frame-type flag and a signed integer-pel motion vector. For an intra block each residual is clamped into the pixel range and becomes the final sample. For a predicted block the reference sample is read from the previous picture at the motion-vector offset. The edge-clamped coordinates pick that sample. The residual is added and the sum is saturated. In both cases the result leaves on a pixel output stream and is also written into the current picture store, so that later predicted pictures can use it.

Two single-port picture memories sit outside the block and have a one-cycle read latency. In any cycle one of them is the current store and is only written. The other is the reference store and is only read. A picture-end pulse swaps the two roles. The block takes one residual per cycle through a ready/valid handshake. The command must be issued before the first residual of each block.

Top module: `mc_recon`

## Requirements
- R1: After reset res_ready and pix_valid are 0, cmd_ready is 1, neither memory is written, memory 0 is the current (written) store and memory 1 the reference (read) store.
- R2: A command accepted while cmd_ready is 1 raises res_ready in the next cycle. Exactly 64 residuals are then taken (res_valid and res_ready both 1 at a clock edge), and res_ready is 0 in the cycle after the 64th.
- R3: With cmd_pred = 0 (intra) each output pixel is the residual clamped into 0..255, and no reference sample is used.
- R4: With cmd_pred = 1 (predicted) each output pixel is the reference-store sample at (x + mv_x, y + mv_y) plus the residual. The motion vector components are 5-bit two's complement (-16..15) and residuals are 9-bit two's complement.
- R5: Every sum is saturated: a negative sum gives 0 and a sum above 255 gives 255.
- R6: Reference coordinates that fall outside the picture are clamped to 0..W-1 horizontally and 0..H-1 vertically.
- R7: Residual k of a block (row k/8, column k%8) gives the k-th output pixel. pix_valid is 1 two clock edges after the acceptance edge of that residual, and cycles without res_valid only delay the output.
- R8: A frame_done pulse swaps the current and reference stores only when no block is in progress and the pipeline is empty. Otherwise it is ignored.
- R9: cmd_valid while cmd_ready is 0 is ignored: the running block keeps its position, type and motion vector.
- R10: Each output pixel is written to the current store at address y*W + x, where x = blk_x*8 + column and y = blk_y*8 + row. The two write enables are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Block command strobe |
| cmd_ready | output | 1 | Block accepts a command |
| cmd_pred | input | 1 | 1 = predicted block, 0 = intra block |
| cmd_blk_x | input | BX_W | Block column index |
| cmd_blk_y | input | BY_W | Block row index |
| cmd_mv_x | input | MV_W | Signed horizontal motion vector |
| cmd_mv_y | input | MV_W | Signed vertical motion vector |
| frame_done | input | 1 | Picture-end pulse, swaps store roles |
| res_valid | input | 1 | Residual sample valid |
| res_ready | output | 1 | Residual sample accepted |
| res_data | input | RES_W | Signed residual sample |
| pix_valid | output | 1 | Reconstructed pixel valid |
| pix_data | output | PIX_W | Reconstructed pixel |
| mem0_addr | output | ADDR_W | Memory 0 address (read or write) |
| mem0_we | output | 1 | Memory 0 write enable |
| mem0_wdata | output | PIX_W | Memory 0 write data |
| mem0_rdata | input | PIX_W | Memory 0 read data, one cycle after address |
| mem1_addr | output | ADDR_W | Memory 1 address (read or write) |
| mem1_we | output | 1 | Memory 1 write enable |
| mem1_wdata | output | PIX_W | Memory 1 write data |
| mem1_rdata | input | PIX_W | Memory 1 read data, one cycle after address |

## Verification
An intra block with a residual ramp from -256 upward shows the low clamp and the plain pass-through. A predicted block with a zero vector and residuals that alternate between +255 and -256 drives both saturation limits over real reference data. Blocks in the top-left and bottom-right corners with extreme vectors distinguish clamped from wrapped or unclamped coordinates. A block fed with gaps while a stray command and a picture-end pulse arrive mid-block shows whether the order and latency hold and whether those strobes are ignored. Chaining a predicted block onto the store written by an earlier one shows that the store roles are swapped only by an idle picture-end pulse.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mc_state_t;
endpackage

// File: rtl/mc_addr_gen.sv
module mc_addr_gen #(
  parameter int W       = 176,
  parameter int H       = 144,
  parameter int LOG_BLK = 3,
  parameter int BX_W    = 5,
  parameter int BY_W    = 5,
  parameter int MV_W    = 5,
  parameter int ADDR_W  = 15,
  localparam int IDX_W  = 2 * LOG_BLK
) (
  input  logic [BX_W-1:0]         blk_x,
  input  logic [BY_W-1:0]         blk_y,
  input  logic signed [MV_W-1:0]  mv_x,
  input  logic signed [MV_W-1:0]  mv_y,
  input  logic                    pred,
  input  logic [IDX_W-1:0]        idx,
  output logic [ADDR_W-1:0]       rd_addr,
  output logic [ADDR_W-1:0]       wr_addr
);
  localparam int CW = $clog2((W > H) ? W : H) + 2;
  localparam logic signed [CW-1:0] XMAX = CW'(W - 1);
  localparam logic signed [CW-1:0] YMAX = CW'(H - 1);

  logic [LOG_BLK-1:0] col, row;
  logic signed [CW-1:0] px, py, dx, dy, rx, ry, cx, cy;

  assign col = idx[LOG_BLK-1:0];
  assign row = idx[IDX_W-1:LOG_BLK];

  always_comb begin
    px = signed'({{(CW-BX_W-LOG_BLK){1'b0}}, blk_x, col});
    py = signed'({{(CW-BY_W-LOG_BLK){1'b0}}, blk_y, row});
    dx = pred ? {{(CW-MV_W){mv_x[MV_W-1]}}, mv_x} : '0;
    dy = pred ? {{(CW-MV_W){mv_y[MV_W-1]}}, mv_y} : '0;
    rx = px + dx;
    ry = py + dy;
    if (rx < 0)          cx = '0;
    else if (rx > XMAX)  cx = XMAX;
    else                 cx = rx;
    if (ry < 0)          cy = '0;
    else if (ry > YMAX)  cy = YMAX;
    else                 cy = ry;
    rd_addr = ADDR_W'(cy) * ADDR_W'(W) + ADDR_W'(cx);
    wr_addr = ADDR_W'(py) * ADDR_W'(W) + ADDR_W'(px);
  end
endmodule

// File: rtl/mc_sat_add.sv
module mc_sat_add #(
  parameter int PIX_W  = 8,
  parameter int RES_W  = 9,
  parameter int ADDR_W = 15
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic                     in_pred,
  input  logic signed [RES_W-1:0]  in_res,
  input  logic [PIX_W-1:0]         in_ref,
  input  logic [ADDR_W-1:0]        in_addr,
  output logic                     out_valid,
  output logic [PIX_W-1:0]         out_pix,
  output logic [ADDR_W-1:0]        out_addr
);
  localparam int SW = ((RES_W > PIX_W + 1) ? RES_W : PIX_W + 1) + 1;
  localparam logic signed [SW-1:0] PMAX = SW'((1 << PIX_W) - 1);

  logic signed [SW-1:0] ref_e, res_e, sum;

  always_comb begin
    ref_e = in_pred ? signed'({{(SW-PIX_W){1'b0}}, in_ref}) : '0;
    res_e = {{(SW-RES_W){in_res[RES_W-1]}}, in_res};
    sum   = ref_e + res_e;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
      out_addr  <= '0;
    end else begin
      out_valid <= in_valid;
      out_addr  <= in_addr;
      if (sum < 0)         out_pix <= '0;
      else if (sum > PMAX) out_pix <= '1;
      else                 out_pix <= sum[PIX_W-1:0];
    end
  end

  AST_SAT_LOW: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sum < 0) |=> (out_pix == '0)); // R5
  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sum > PMAX) |=> (out_pix == '1)); // R5
endmodule

// File: rtl/mc_recon.sv
module mc_recon
  import mc_pkg::*;
#(
  parameter int FRAME_W = 176,
  parameter int FRAME_H = 144,
  parameter int BLK     = 8,
  parameter int PIX_W   = 8,
  parameter int RES_W   = 9,
  parameter int MV_W    = 5,
  localparam int LOG_BLK = $clog2(BLK),
  localparam int IDX_W   = 2 * LOG_BLK,
  localparam int BX_W    = $clog2(FRAME_W / BLK),
  localparam int BY_W    = $clog2(FRAME_H / BLK),
  localparam int ADDR_W  = $clog2(FRAME_W * FRAME_H)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cmd_valid,
  output logic                     cmd_ready,
  input  logic                     cmd_pred,
  input  logic [BX_W-1:0]          cmd_blk_x,
  input  logic [BY_W-1:0]          cmd_blk_y,
  input  logic signed [MV_W-1:0]   cmd_mv_x,
  input  logic signed [MV_W-1:0]   cmd_mv_y,
  input  logic                     frame_done,
  input  logic                     res_valid,
  output logic                     res_ready,
  input  logic signed [RES_W-1:0]  res_data,
  output logic                     pix_valid,
  output logic [PIX_W-1:0]         pix_data,
  output logic [ADDR_W-1:0]        mem0_addr,
  output logic                     mem0_we,
  output logic [PIX_W-1:0]         mem0_wdata,
  input  logic [PIX_W-1:0]         mem0_rdata,
  output logic [ADDR_W-1:0]        mem1_addr,
  output logic                     mem1_we,
  output logic [PIX_W-1:0]         mem1_wdata,
  input  logic [PIX_W-1:0]         mem1_rdata
);
  localparam logic [IDX_W-1:0] LAST_IDX = '1;

  mc_state_t               st;
  logic                    cur_sel;   // store being written: 0 or 1
  logic [BX_W-1:0]         bx_q;
  logic [BY_W-1:0]         by_q;
  logic signed [MV_W-1:0]  mvx_q, mvy_q;
  logic                    pred_q;
  logic [IDX_W-1:0]        idx;
  logic                    s1_valid, s1_pred;
  logic signed [RES_W-1:0] s1_res;
  logic [ADDR_W-1:0]       s1_waddr;
  logic [ADDR_W-1:0]       rd_addr, wr_addr, wq_addr;
  logic [PIX_W-1:0]        ref_pix;
  logic                    accept, pipe_busy, swap_ok;

  assign cmd_ready = (st == ST_IDLE);
  assign res_ready = (st == ST_RUN);
  assign accept    = res_valid && res_ready;
  assign pipe_busy = (st != ST_IDLE) || s1_valid || pix_valid;
  assign swap_ok   = frame_done && !pipe_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cur_sel  <= 1'b0;
      bx_q     <= '0;
      by_q     <= '0;
      mvx_q    <= '0;
      mvy_q    <= '0;
      pred_q   <= 1'b0;
      idx      <= '0;
      s1_valid <= 1'b0;
      s1_pred  <= 1'b0;
      s1_res   <= '0;
      s1_waddr <= '0;
    end else begin
      if (swap_ok) cur_sel <= ~cur_sel;
      case (st)
        ST_IDLE: if (cmd_valid) begin
          bx_q   <= cmd_blk_x;
          by_q   <= cmd_blk_y;
          mvx_q  <= cmd_mv_x;
          mvy_q  <= cmd_mv_y;
          pred_q <= cmd_pred;
          idx    <= '0;
          st     <= ST_RUN;
        end
        ST_RUN: if (accept) begin
          idx <= idx + 1'b1;
          if (idx == LAST_IDX) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
      s1_valid <= accept;
      if (accept) begin
        s1_res   <= res_data;
        s1_waddr <= wr_addr;
        s1_pred  <= pred_q;
      end
    end
  end

  mc_addr_gen #(
    .W(FRAME_W), .H(FRAME_H), .LOG_BLK(LOG_BLK), .BX_W(BX_W), .BY_W(BY_W),
    .MV_W(MV_W), .ADDR_W(ADDR_W)
  ) u_addr (
    .blk_x(bx_q), .blk_y(by_q), .mv_x(mvx_q), .mv_y(mvy_q), .pred(pred_q),
    .idx(idx), .rd_addr(rd_addr), .wr_addr(wr_addr)
  );

  // reference store is the one not being written
  assign ref_pix = cur_sel ? mem0_rdata : mem1_rdata;

  mc_sat_add #(.PIX_W(PIX_W), .RES_W(RES_W), .ADDR_W(ADDR_W)) u_sat (
    .clk(clk), .rst(rst), .in_valid(s1_valid), .in_pred(s1_pred),
    .in_res(s1_res), .in_ref(ref_pix), .in_addr(s1_waddr),
    .out_valid(pix_valid), .out_pix(pix_data), .out_addr(wq_addr)
  );

  assign mem0_addr  = cur_sel ? rd_addr : wq_addr;
  assign mem0_we    = !cur_sel && pix_valid;
  assign mem0_wdata = pix_data;
  assign mem1_addr  = cur_sel ? wq_addr : rd_addr;
  assign mem1_we    = cur_sel && pix_valid;
  assign mem1_wdata = pix_data;

  AST_ONE_BANK_WR: assert property (@(posedge clk) disable iff (rst)
    !(mem0_we && mem1_we)); // R10
  AST_SWAP_IDLE: assert property (@(posedge clk) disable iff (rst)
    (cur_sel != $past(cur_sel)) |-> $past(frame_done && st == ST_IDLE && !s1_valid && !pix_valid)); // R8
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
    (accept && idx == LAST_IDX) |=> !res_ready); // R2
  AST_PIX_LATENCY: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> $past(res_valid && res_ready, 2)); // R7
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && $past(st == ST_RUN)) |-> ($stable(mvx_q) && $stable(bx_q) && $stable(pred_q))); // R9
endmodule

// File: tb/tb_mc_recon.sv
`timescale 1ns/1ps
module tb_mc_recon;
  localparam int W = 32;
  localparam int H = 24;
  localparam int N = W * H;
  localparam int AW = $clog2(N);
  localparam int MVW = 5;
  localparam int RW = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic cmd_valid = 0, cmd_ready, cmd_pred = 0;
  logic [1:0] cmd_blk_x = 0, cmd_blk_y = 0;
  logic signed [MVW-1:0] cmd_mv_x = 0, cmd_mv_y = 0;
  logic frame_done = 0, res_valid = 0, res_ready, pix_valid;
  logic signed [RW-1:0] res_data = 0;
  logic [7:0] pix_data;
  logic [AW-1:0] mem0_addr, mem1_addr;
  logic mem0_we, mem1_we;
  logic [7:0] mem0_wdata, mem1_wdata, mem0_rdata, mem1_rdata;

  mc_recon #(.FRAME_W(W), .FRAME_H(H)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_pred(cmd_pred), .cmd_blk_x(cmd_blk_x), .cmd_blk_y(cmd_blk_y),
    .cmd_mv_x(cmd_mv_x), .cmd_mv_y(cmd_mv_y), .frame_done(frame_done),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .pix_valid(pix_valid), .pix_data(pix_data),
    .mem0_addr(mem0_addr), .mem0_we(mem0_we), .mem0_wdata(mem0_wdata), .mem0_rdata(mem0_rdata),
    .mem1_addr(mem1_addr), .mem1_we(mem1_we), .mem1_wdata(mem1_wdata), .mem1_rdata(mem1_rdata)
  );

  // picture memories with preload port
  logic [7:0] m0 [N];
  logic [7:0] m1 [N];
  logic ld_en = 0, ld_bank = 0;
  logic [AW-1:0] ld_addr = 0;
  logic [7:0] ld_data = 0;
  always @(posedge clk) begin
    if (ld_en && !ld_bank) m0[ld_addr] <= ld_data;
    else if (mem0_we) m0[mem0_addr] <= mem0_wdata;
    if (ld_en && ld_bank) m1[ld_addr] <= ld_data;
    else if (mem1_we) m1[mem1_addr] <= mem1_wdata;
    mem0_rdata <= m0[mem0_addr];
    mem1_rdata <= m1[mem1_addr];
  end

  // output capture
  logic [7:0] cap [1024];
  int cap_n = 0;
  always @(negedge clk) begin
    if (pix_valid && cap_n < 1024) begin
      cap[cap_n] <= pix_data;
      cap_n <= cap_n + 1;
    end
  end

  int checks = 0, errors = 0;
  int exp_cur = 0;
  int res_arr [64];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clampi(input int v, input int hi);
    if (v < 0) return 0;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic int refpix(input int a);
    // reference store is the one not currently written
    return (exp_cur == 1) ? int'(m0[a]) : int'(m1[a]);
  endfunction

  function automatic int curpix(input int a);
    return (exp_cur == 1) ? int'(m1[a]) : int'(m0[a]);
  endfunction

  task automatic run_block(input int bx, input int by, input int pred, input int mvx, input int mvy,
                           input int stall, input int inject, input string tag);
    int expv [64];
    int wa [64];
    int base, idx, cyc;
    for (int k = 0; k < 64; k++) begin
      int r, c, px, py, rv, s;
      r = k / 8; c = k % 8;
      px = bx * 8 + c; py = by * 8 + r;
      wa[k] = py * W + px;
      rv = pred ? refpix(clampi(py + mvy, H - 1) * W + clampi(px + mvx, W - 1)) : 0;
      s = rv + res_arr[k];
      expv[k] = clampi(s, 255);
    end
    base = cap_n;
    @(negedge clk);
    cmd_valid = 1; cmd_pred = pred[0]; cmd_blk_x = 2'(bx); cmd_blk_y = 2'(by);
    cmd_mv_x = MVW'(mvx); cmd_mv_y = MVW'(mvy);
    @(negedge clk);
    cmd_valid = 0;
    chk(res_ready == 1'b1, "R2 ready after cmd", int'(res_ready), 1);
    idx = 0; cyc = 0;
    while (idx < 64) begin
      if (cyc > 0) @(negedge clk);
      if (inject != 0 && idx == 20) begin
        chk(cmd_ready == 1'b0, "R9 cmd_ready low mid-block", int'(cmd_ready), 0);
        cmd_valid = 1; cmd_pred = 0; cmd_mv_x = 0; cmd_mv_y = 0; cmd_blk_x = 0; frame_done = 1;
      end else begin
        cmd_valid = 0; frame_done = 0;
      end
      if (stall != 0 && (cyc % 3) == 1) res_valid = 0;
      else begin
        res_valid = 1;
        res_data = RW'(res_arr[idx]);
        if (res_ready) idx++;
      end
      cyc++;
    end
    @(negedge clk);
    res_valid = 0; cmd_valid = 0; frame_done = 0;
    chk(res_ready == 1'b0, "R2 ready low after 64", int'(res_ready), 0);
    repeat (4) @(negedge clk);
    chk(cap_n - base == 64, "R7 pixel count", cap_n - base, 64);
    for (int k = 0; k < 64; k++) begin
      chk(int'(cap[base + k]) == expv[k], tag, int'(cap[base + k]), expv[k]);
      chk(curpix(wa[k]) == expv[k], "R10 store write", curpix(wa[k]), expv[k]);
    end
  endtask

  task automatic pulse_frame_done();
    @(negedge clk); frame_done = 1;
    @(negedge clk); frame_done = 0;
    exp_cur = 1 - exp_cur;
  endtask

  task automatic t_reset();
    chk(pix_valid == 0, "R1 pix_valid", int'(pix_valid), 0);
    chk(res_ready == 0, "R1 res_ready", int'(res_ready), 0);
    chk(cmd_ready == 1, "R1 cmd_ready", int'(cmd_ready), 1);
    chk(!mem0_we && !mem1_we, "R1 no write", int'(mem0_we | mem1_we), 0);
  endtask

  task automatic t_intra();   // R3, R5 low clamp, R1 store 0 written
    for (int k = 0; k < 64; k++) res_arr[k] = k * 8 - 256;
    run_block(1, 1, 0, 0, 0, 0, 0, "R3 intra pixel");
    chk(int'(m0[(8 + 7) * W + 8 + 7]) == 248, "R1 store0 current", int'(m0[15 * W + 15]), 248);
  endtask

  task automatic t_pred_sat();   // R4, R5, R8 swap when idle
    pulse_frame_done();
    for (int k = 0; k < 64; k++) res_arr[k] = (k % 2 == 0) ? 255 : -256;
    res_arr[3] = 5; res_arr[10] = -7;
    run_block(1, 1, 1, 0, 0, 0, 0, "R4 R5 pred saturate");
  endtask

  task automatic t_corner_tl();   // R6, R7 with gaps
    for (int k = 0; k < 64; k++) res_arr[k] = k - 32;
    run_block(0, 0, 1, -16, -16, 1, 0, "R6 R7 top-left clamp");
  endtask

  task automatic t_corner_br();   // R6, R8 and R9 ignore
    for (int k = 0; k < 64; k++) res_arr[k] = 3 * k - 90;
    run_block(3, 2, 1, 15, 15, 0, 1, "R6 R9 bottom-right");
  endtask

  task automatic t_after_ignore();   // R8: roles unchanged by busy pulse
    for (int k = 0; k < 64; k++) res_arr[k] = 17 - k;
    run_block(2, 1, 1, 5, -3, 0, 0, "R8 roles kept");
  endtask

  task automatic t_chain();   // R8 swap back, R4 chained reference
    pulse_frame_done();
    for (int k = 0; k < 64; k++) res_arr[k] = (k % 5) * 9 - 20;
    run_block(1, 1, 1, 1, 2, 1, 0, "R4 R8 chained");
  endtask

  initial begin
    for (int b = 0; b < 2; b++) begin
      for (int a = 0; a < N; a++) begin
        @(negedge clk);
        ld_en = 1; ld_bank = b[0]; ld_addr = AW'(a);
        ld_data = (b == 0) ? 8'((a * 7 + 3) & 255) : 8'((a * 13 + 100) & 255);
      end
    end
    @(negedge clk); ld_en = 0;
    @(negedge clk); rst = 0;
    @(negedge clk);
    t_reset();
    t_intra();
    t_pred_sat();
    t_corner_tl();
    t_corner_br();
    t_after_ignore();
    t_chain();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule